// File: doc/BRIEF.md
# Shared-Prescaler Timer and Watchdog

This block holds an 8-bit free-running counter and a watchdog timer. The two share one 8-bit prescaler. An 8-bit mode register sets the divide ratio, which of the two the prescaler serves, the counter's clock source and the active edge of the external pin. The counter advances on either the instruction-cycle strobe or edges of an external pin. That pin passes through a two-flop synchronizer first. The counter can be loaded at any time and wraps from FFh to 00h.

The watchdog advances on a base tick. It can be forced on by build option, or enabled in software through mode bit 7. A clear-watchdog strobe and a sleep strobe restart it. When it times out, it emits a one-cycle reset pulse and restores the mode register. Two status flags record how the last restart happened: one for timeout and one for power. While asleep, the counter is frozen. A watchdog timeout is the only exit from sleep.

Top module: `tmr_wdt_core`

## Requirements
- R1: After reset the mode register reads FFh, the counter reads 00h, both status flags are 1, and the sleep and timeout-pulse outputs are 0.
- R2: With mode bit 5 = 0 and mode bit 3 = 0, the counter advances once per 2^(p+1) instruction-cycle strobes, where p is mode bits 2..0.
- R3: With mode bit 3 = 1, the counter advances on every selected source event. The watchdog then advances once per 2^p base ticks.
- R4: With mode bit 5 = 1, the counter ignores cycle strobes and counts pin edges seen through a two-flop synchronizer. Mode bit 4 = 0 selects rising edges and 1 selects falling edges.
- R5: A counter write loads the written value and restarts the prescaler count. The counter wraps from FFh to 00h.
- R6: The watchdog runs when the always-on option is set, or when software enable is allowed and mode bit 7 = 0. Otherwise it never times out.
- R7: The watchdog times out on the 2^WDT_W-th advance after its last restart. The timeout pulse is high for exactly one cycle. The mode register returns to FFh, the timeout flag becomes 0, and the power flag becomes 1 if the block was awake.
- R8: A clear-watchdog strobe restarts the watchdog count and sets both flags to 1.
- R9: A sleep strobe restarts the watchdog, sets the timeout flag to 1 and the power flag to 0, and freezes the counter. A timeout while asleep leaves both flags 0 and ends sleep.
- R10: A mode register write restarts the prescaler count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_stb | input | 1 | Instruction-cycle strobe |
| ext_pin | input | 1 | External count pin, asynchronous |
| wdt_tick | input | 1 | Watchdog base tick |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write data |
| clrwdt_stb | input | 1 | Clear-watchdog strobe |
| sleep_stb | input | 1 | Enter-sleep strobe |
| cnt_q | output | 8 | Counter value |
| mode_q | output | 8 | Mode register value |
| wdt_rst | output | 1 | One-cycle watchdog timeout pulse |
| tmo_flag | output | 1 | Timeout status flag |
| pwr_flag | output | 1 | Power status flag |
| sleeping | output | 1 | Sleep state |

## Verification
All eight divide codes are swept with the prescaler on the counter. Each code stops one strobe short of the third advance and then adds the final strobe, which tells an off-by-one ratio from a correct one. The same sweep runs with the prescaler on the watchdog: each run stops one tick short of timeout and then adds the last tick, which separates the halved ratio from the counter's ratio. Pin pulses in both polarities, with cycle strobes mixed in, show edge selection and source exclusion. Writes placed in the middle of a prescaler period, a restart in the middle of a watchdog period, and a timeout during sleep tell each restart source and flag pattern apart.

// File: rtl/tw_pkg.sv
// Shared types and helpers for the timer/watchdog block.
// Assumes an 8-bit prescaler and a 3-bit ratio select.
package tw_pkg;
    localparam int PRE_W = 8;

    typedef struct packed {
        logic       wdt_off;    // 1: software watchdog enable off
        logic       spare;      // general purpose, no effect
        logic       src_ext;    // 1: count external pin edges
        logic       fall_edge;  // 1: falling edge active
        logic       pre_to_wdt; // 1: prescaler serves watchdog
        logic [2:0] ps;         // divide select
    } mode_t;

    localparam logic [7:0] MODE_RST = 8'hFF;

    // Low-order mask whose all-ones state marks the last event of a period
    function automatic logic [PRE_W-1:0] tap_mask(input logic [2:0] ps, input logic for_wdt);
        logic [3:0]       n;
        logic [PRE_W-1:0] msk;
        n = {1'b0, ps} + (for_wdt ? 4'd0 : 4'd1);
        for (int i = 0; i < PRE_W; i++) msk[i] = (4'(i) < n);
        return msk;
    endfunction
endpackage

// File: rtl/tw_pin_edge.sv
// Synchronizes an asynchronous pin and flags one selected edge per transition.
// Assumes the pin is stable for at least two clocks between transitions.
module tw_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic evt
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh;

    // Shift the pin through the synchronizer and one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SH_W-2:0], pin};
    end

    assign evt = fall_sel ? (sh[SH_W-1] & ~sh[SH_W-2])
                          : (~sh[SH_W-1] & sh[SH_W-2]);
endmodule

// File: rtl/tw_prescaler.sv
// Event divider: counts input events and emits a tick on the last event of a
// period given by a low-order mask. A clear restarts the count.
// Assumes evt is a single-cycle qualifier.
module tw_prescaler
    import tw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             evt,
    input  logic [PRE_W-1:0] mask,
    output logic             tick
);
    logic [PRE_W-1:0] cnt;

    // Advance on each event, restart on clear
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (evt) cnt <= cnt + 1'b1;
    end

    assign tick = evt && ((cnt & mask) == mask);
endmodule

// File: rtl/tw_watchdog.sv
// Watchdog counter with restart, sleep state and the two status flags.
// Assumes inc is a single-cycle qualifier; restarts win over an advance.
module tw_watchdog #(
    parameter int WDT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic inc,
    input  logic clr,
    input  logic slp,
    output logic fire,
    output logic rst_pulse,
    output logic tmo_flag,
    output logic pwr_flag,
    output logic sleeping
);
    logic [WDT_W-1:0] cnt;

    assign fire = en && inc && !clr && !slp && (cnt == {WDT_W{1'b1}});

    // Watchdog count: restarted by strobes, timeout or disable
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt <= '0;
        else if (clr || slp || fire || !en) cnt <= '0;
        else if (inc)                      cnt <= cnt + 1'b1;
    end

    // Status flags and sleep state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_flag <= 1'b1;
            pwr_flag <= 1'b1;
            sleeping <= 1'b0;
        end else if (fire) begin
            tmo_flag <= 1'b0;
            pwr_flag <= ~sleeping;
            sleeping <= 1'b0;
        end else if (slp) begin
            tmo_flag <= 1'b1;
            pwr_flag <= 1'b0;
            sleeping <= 1'b1;
        end else if (clr) begin
            tmo_flag <= 1'b1;
            pwr_flag <= 1'b1;
        end
    end

    // Registered one-cycle timeout pulse
    always_ff @(posedge clk) begin
        if (!rst_n) rst_pulse <= 1'b0;
        else        rst_pulse <= fire;
    end
endmodule

// File: rtl/tmr_wdt_core.sv
// 8-bit counter and watchdog sharing one prescaler, steered by a mode register.
// Assumes strobes are single-cycle and synchronous to clk; ext_pin is asynchronous.
module tmr_wdt_core
    import tw_pkg::*;
#(
    parameter int WDT_W           = 8,
    parameter bit FUSE_WDT_ALWAYS = 1'b0,
    parameter bit SW_WDT_ALLOW    = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_stb,
    input  logic       ext_pin,
    input  logic       wdt_tick,
    input  logic       mode_we,
    input  logic [7:0] mode_wdata,
    input  logic       cnt_we,
    input  logic [7:0] cnt_wdata,
    input  logic       clrwdt_stb,
    input  logic       sleep_stb,
    output logic [7:0] cnt_q,
    output logic [7:0] mode_q,
    output logic       wdt_rst,
    output logic       tmo_flag,
    output logic       pwr_flag,
    output logic       sleeping
);
    mode_t            mode_r;
    logic             wdt_en;
    logic             ext_evt;
    logic             tmr_evt;
    logic             pre_evt;
    logic             pre_clr;
    logic             pre_tick;
    logic [PRE_W-1:0] pre_mask;
    logic             cnt_inc;
    logic             wdt_inc;
    logic             fire;
    logic [7:0]       cnt_r;

    // Watchdog enable variant picked by build options
    generate
        if (FUSE_WDT_ALWAYS) begin : g_wdt_fixed
            assign wdt_en = 1'b1;
        end else if (SW_WDT_ALLOW) begin : g_wdt_sw
            assign wdt_en = ~mode_r.wdt_off;
        end else begin : g_wdt_never
            assign wdt_en = 1'b0;
        end
    endgenerate

    // Mode register: restored on timeout, else written by software
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_r <= mode_t'(MODE_RST);
        else if (fire)    mode_r <= mode_t'(MODE_RST);
        else if (mode_we) mode_r <= mode_t'(mode_wdata);
    end

    tw_pin_edge #(.SYNC_STAGES(2)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_pin),
        .fall_sel (mode_r.fall_edge),
        .evt      (ext_evt)
    );

    assign tmr_evt  = !sleeping && (mode_r.src_ext ? ext_evt : cyc_stb);
    assign pre_evt  = mode_r.pre_to_wdt ? (wdt_tick && wdt_en) : tmr_evt;
    assign pre_mask = tap_mask(mode_r.ps, mode_r.pre_to_wdt);
    assign pre_clr  = cnt_we || mode_we || fire
                   || (mode_r.pre_to_wdt && (clrwdt_stb || sleep_stb));

    tw_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .evt   (pre_evt),
        .mask  (pre_mask),
        .tick  (pre_tick)
    );

    assign cnt_inc = mode_r.pre_to_wdt ? tmr_evt : pre_tick;
    assign wdt_inc = mode_r.pre_to_wdt ? pre_tick : (wdt_tick && wdt_en);

    // Counter: load wins over advance; wraps naturally
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_r <= '0;
        else if (cnt_we)  cnt_r <= cnt_wdata;
        else if (cnt_inc) cnt_r <= cnt_r + 8'd1;
    end

    tw_watchdog #(.WDT_W(WDT_W)) u_wdt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (wdt_en),
        .inc       (wdt_inc),
        .clr       (clrwdt_stb),
        .slp       (sleep_stb),
        .fire      (fire),
        .rst_pulse (wdt_rst),
        .tmo_flag  (tmo_flag),
        .pwr_flag  (pwr_flag),
        .sleeping  (sleeping)
    );

    assign cnt_q  = cnt_r;
    assign mode_q = mode_r;
endmodule

// File: rtl/tmr_wdt_core_chk.sv
// Port-level temporal checks for tmr_wdt_core, attached with bind.
// Assumes synchronous active-low reset on rst_n.
module tmr_wdt_core_chk #(
    parameter bit FUSE_WDT_ALWAYS = 1'b0,
    parameter bit SW_WDT_ALLOW    = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cnt_we,
    input logic [7:0] cnt_wdata,
    input logic       clrwdt_stb,
    input logic       sleep_stb,
    input logic [7:0] cnt_q,
    input logic [7:0] mode_q,
    input logic       wdt_rst,
    input logic       tmo_flag,
    input logic       pwr_flag,
    input logic       sleeping
);
    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> cnt_q == $past(cnt_wdata));

    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_we |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 8'd1));

    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);

    a_r7_restore: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> (mode_q == 8'hFF) && !tmo_flag);

    a_r8_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (clrwdt_stb && !sleep_stb) |=> tmo_flag && pwr_flag);

    a_r9_enter: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_stb |=> sleeping && tmo_flag && !pwr_flag);

    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && !cnt_we) |=> $stable(cnt_q));

    generate
        if (!FUSE_WDT_ALWAYS) begin : g_sw
            a_r6_disabled: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_q[7] || !SW_WDT_ALLOW) |=> !wdt_rst);
        end
    endgenerate
endmodule

bind tmr_wdt_core tmr_wdt_core_chk #(
    .FUSE_WDT_ALWAYS (FUSE_WDT_ALWAYS),
    .SW_WDT_ALLOW    (SW_WDT_ALLOW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_we     (cnt_we),
    .cnt_wdata  (cnt_wdata),
    .clrwdt_stb (clrwdt_stb),
    .sleep_stb  (sleep_stb),
    .cnt_q      (cnt_q),
    .mode_q     (mode_q),
    .wdt_rst    (wdt_rst),
    .tmo_flag   (tmo_flag),
    .pwr_flag   (pwr_flag),
    .sleeping   (sleeping)
);

// File: tb/tmr_wdt_core_tb.sv
`timescale 1ns/1ps
module tmr_wdt_core_tb;
    localparam int WDT_W = 4;
    localparam int WDT_N = 1 << WDT_W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_stb = 1'b0, ext_pin = 1'b0, wdt_tick = 1'b0;
    logic       mode_we = 1'b0, cnt_we = 1'b0, clrwdt_stb = 1'b0, sleep_stb = 1'b0;
    logic [7:0] mode_wdata = '0, cnt_wdata = '0;
    logic [7:0] cnt_q, mode_q;
    logic       wdt_rst, tmo_flag, pwr_flag, sleeping;

    int checks = 0, failures = 0, rst_seen = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tmr_wdt_core #(.WDT_W(WDT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .ext_pin(ext_pin),
        .wdt_tick(wdt_tick), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .clrwdt_stb(clrwdt_stb),
        .sleep_stb(sleep_stb), .cnt_q(cnt_q), .mode_q(mode_q), .wdt_rst(wdt_rst),
        .tmo_flag(tmo_flag), .pwr_flag(pwr_flag), .sleeping(sleeping)
    );

    always @(posedge clk) if (rst_n && wdt_rst) rst_seen++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) begin
            @(negedge clk) cyc_stb = 1'b1;
            @(negedge clk) cyc_stb = 1'b0;
        end
    endtask

    task automatic wtick(input int n);
        repeat (n) begin
            @(negedge clk) wdt_tick = 1'b1;
            @(negedge clk) wdt_tick = 1'b0;
        end
    endtask

    task automatic wr_mode(input logic [7:0] v);
        @(negedge clk) begin mode_we = 1'b1; mode_wdata = v; end
        @(negedge clk) mode_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        @(negedge clk) begin cnt_we = 1'b1; cnt_wdata = v; end
        @(negedge clk) cnt_we = 1'b0;
    endtask

    task automatic pin(input logic v);
        @(negedge clk) ext_pin = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic strobe_clr();
        @(negedge clk) clrwdt_stb = 1'b1;
        @(negedge clk) clrwdt_stb = 1'b0;
    endtask

    task automatic strobe_sleep();
        @(negedge clk) sleep_stb = 1'b1;
        @(negedge clk) sleep_stb = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 mode", mode_q, 8'hFF);
        chk("R1 count", cnt_q, 8'h00);
        chk("R1 flags", {tmo_flag, pwr_flag, sleeping, wdt_rst}, 4'b1100);

        // R2: internal source, prescaler on counter, all ratios
        for (int p = 0; p < 8; p++) begin
            wr_mode(8'hC0 | 8'(p));
            wr_cnt(8'h00);
            cyc(3 * (2 << p) - 1);
            chk($sformatf("R2 ps=%0d short", p), cnt_q, 8'd2);
            cyc(1);
            chk($sformatf("R2 ps=%0d full", p), cnt_q, 8'd3);
        end

        // R10: mode write restarts the prescaler
        wr_mode(8'hC2); wr_cnt(8'h00); cyc(5);
        wr_mode(8'hC2); cyc(7);
        chk("R10 after mode write", cnt_q, 8'd0);
        cyc(1);
        chk("R10 first period", cnt_q, 8'd1);

        // R5: counter write loads and restarts the prescaler; wrap
        wr_cnt(8'h00); cyc(5);
        wr_cnt(8'd10); cyc(7);
        chk("R5 load", cnt_q, 8'd10);
        cyc(1);
        chk("R5 restart", cnt_q, 8'd11);
        wr_mode(8'hC8); wr_cnt(8'hFE); cyc(2);
        chk("R5 wrap", cnt_q, 8'h00);

        // R3: prescaler on watchdog leaves counter at 1:1
        wr_mode(8'hCF); wr_cnt(8'h00); cyc(5);
        chk("R3 counter 1:1", cnt_q, 8'd5);

        // R4: external pin, rising then falling
        wr_mode(8'hE8); wr_cnt(8'h00);
        for (int k = 0; k < 3; k++) begin pin(1'b1); pin(1'b0); end
        cyc(4);
        chk("R4 rising count", cnt_q, 8'd3);
        wr_mode(8'hF8); wr_cnt(8'h00);
        pin(1'b1);
        chk("R4 falling ignores rise", cnt_q, 8'd0);
        pin(1'b0);
        chk("R4 falling counts fall", cnt_q, 8'd1);

        // R7: timeout with prescaler on watchdog, every ratio
        for (int p = 0; p < 8; p++) begin
            base = rst_seen;
            wr_mode(8'h08 | 8'(p));
            wtick(WDT_N * (1 << p) - 1);
            settle();
            chk($sformatf("R7 ps=%0d early", p), rst_seen, base);
            wtick(1);
            settle();
            chk($sformatf("R7 ps=%0d fire", p), rst_seen, base + 1);
            chk($sformatf("R7 ps=%0d state", p), {mode_q, tmo_flag, pwr_flag}, {8'hFF, 2'b01});
        end
        // R7: watchdog unprescaled
        base = rst_seen;
        wr_mode(8'h00); wtick(WDT_N - 1); settle();
        chk("R7 direct early", rst_seen, base);
        wtick(1); settle();
        chk("R7 direct fire", rst_seen, base + 1);

        // R6: software enable off, no timeout
        base = rst_seen;
        wr_mode(8'h80); wtick(3 * WDT_N); settle();
        chk("R6 disabled", rst_seen, base);

        // R8: clear restarts and sets both flags
        base = rst_seen;
        wr_mode(8'h00); wtick(10); strobe_clr();
        chk("R8 flags", {tmo_flag, pwr_flag}, 2'b11);
        wtick(WDT_N - 1); settle();
        chk("R8 restarted", rst_seen, base);
        wtick(1); settle();
        chk("R8 fire", rst_seen, base + 1);

        // R9: sleep freezes counter, timeout wakes with both flags low
        base = rst_seen;
        wr_mode(8'h00); wr_cnt(8'h40); wtick(5); strobe_sleep();
        chk("R9 enter", {sleeping, tmo_flag, pwr_flag}, 3'b110);
        cyc(5);
        chk("R9 frozen", cnt_q, 8'h40);
        wtick(WDT_N - 1); settle();
        chk("R9 still asleep", {rst_seen - base, 32'(sleeping)}, {32'd0, 32'd1});
        wtick(1); settle();
        chk("R9 wake", {rst_seen - base, 32'({sleeping, tmo_flag, pwr_flag})}, {32'd1, 32'd0});

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule